// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block decides whether a store-exclusive issued by one of several processors may write memory. A processor first issues a load-exclusive. That sets a reservation flag owned by that processor. If the access targets shareable memory, the block also records the reserved physical word in a per-processor slot of a shared reservation table.

A later store-exclusive from the same processor is checked against the reservation state and answered with pass (status 0, write enabled) or fail (status 1, write suppressed). Ordinary stores from any processor remove table reservations that cover the word they write. A successful shareable store-exclusive removes every processor's reservation on its word.

Requests come in one per cycle on a single serialized port. The response appears on the following cycle. Exclusive accesses that break natural alignment can raise an alignment fault, depending on a two-bit alignment-check configuration.

Top module: `excl_monitor`

## Requirements
- R1: Every accepted request (`req_valid`=1) gives exactly one response with `rsp_valid`=1 on the next cycle. A cycle without a request gives `rsp_valid`=0 and all other outputs 0 on the next cycle. After reset, all reservations are clear.
- R2: A load-exclusive (`req_op`=2) sets the issuing processor's private reservation flag. If `req_shared`=1, it also stores the word address `req_addr[ADDR_W-1:2]` as valid in that processor's table slot, replacing any earlier entry. The response is status 0, write-enable 0.
- R3: A store-exclusive (`req_op`=3) from a processor whose private flag is clear returns status 1 with write-enable 0.
- R4: A shareable store-exclusive with the private flag set passes only when that processor's table slot is valid and holds the same word address. Otherwise it returns status 1 with write-enable 0.
- R5: A non-shareable store-exclusive with the private flag set passes (status 0, write-enable 1) and does not consult the table.
- R6: Every non-faulting store-exclusive clears the issuing processor's private flag, whether it passes or fails.
- R7: A passing shareable store-exclusive invalidates every table slot, for any processor, that holds its word address.
- R8: An ordinary store (`req_op`=1) returns status 0 with write-enable 1. It invalidates every table slot holding its word address, whatever `req_shared` is. It leaves the private flags unchanged.
- R9: An exclusive access is misaligned when `req_size`=0 (halfword) and `req_addr[0]`=1, or when `req_size`=1 (word) and `req_addr[1:0]`≠0. When `align_cfg`≠0, a misaligned exclusive returns fault 1, status 1 and write-enable 0, and changes no reservation state. When `align_cfg`=0, no fault is raised and the access proceeds normally.
- R10: Halfword and word exclusives share the same reservation state. A word reservation is satisfied by a halfword store-exclusive anywhere inside that word.
- R11: An ordinary load (`req_op`=0) returns status 0 with write-enable 0 and changes no reservation state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_cpu | input | CPU_W | Issuing processor index |
| req_op | input | 2 | 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| req_addr | input | ADDR_W | Physical byte address |
| req_size | input | 1 | 0 halfword, 1 word |
| req_shared | input | 1 | Access targets shareable memory |
| align_cfg | input | 2 | Alignment-check configuration; nonzero enables faults |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_status | output | 1 | 1 = store-exclusive failed or fault |
| rsp_wr_en | output | 1 | Memory write may proceed |
| rsp_align_fault | output | 1 | Misaligned exclusive access |

## Verification
The bench targets reservations that must be lost. Examples are a second processor's reservation that should die when the first one's shareable store-exclusive succeeds, and an ordinary halfword store into a reserved word. A design that matched on full byte addresses, or cleared only the writer's own slot, would wrongly let the later store-exclusive pass. It also repeats a store-exclusive right after a passing one, which catches a private flag that is not cleared. A faulting load-exclusive is followed by a store-exclusive, which catches a fault that still arms the reservation. Random traffic on a few clustered words then mixes processors, sizes and configurations against an independent model.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LDEX  = 2'd2,
        OP_STEX  = 2'd3
    } excl_op_e;

    typedef enum logic {
        SZ_HALF = 1'b0,
        SZ_WORD = 1'b1
    } excl_size_e;

    typedef struct packed {
        logic valid;
        logic status;
        logic wr_en;
        logic fault;
    } excl_rsp_t;

endpackage

// File: rtl/excl_align_chk.sv
module excl_align_chk
    import excl_mon_pkg::*;
(
    input  logic       is_excl,
    input  logic       size_word,
    input  logic [1:0] addr_lo,
    input  logic [1:0] align_cfg,
    output logic       fault
);
    logic misaligned;

    always_comb begin
        if (size_word == SZ_WORD) begin
            misaligned = (addr_lo != 2'b00);
        end else begin
            misaligned = addr_lo[0];
        end
        fault = is_excl && misaligned && (align_cfg != 2'b00);
    end
endmodule

// File: rtl/excl_local_mon.sv
module excl_local_mon #(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic [CPU_W-1:0]   cpu,
    output logic [NUM_CPU-1:0] flags
);
    logic [NUM_CPU-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = flags_q;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (CPU_W'(i) == cpu) begin
                if (set_en) begin
                    flags_d[i] = 1'b1;
                end else if (clr_en) begin
                    flags_d[i] = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign flags = flags_q;
endmodule

// File: rtl/excl_global_mon.sv
module excl_global_mon #(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2,
    parameter int GRAN_W  = 30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rec_en,
    input  logic               clr_match_en,
    input  logic [CPU_W-1:0]   cpu,
    input  logic [GRAN_W-1:0]  granule,
    output logic               own_hit,
    output logic [NUM_CPU-1:0] slot_valid
);
    typedef struct packed {
        logic              valid;
        logic [GRAN_W-1:0] gran;
    } slot_t;

    slot_t [NUM_CPU-1:0] tab_d, tab_q;
    logic  [NUM_CPU-1:0] match_vec;
    logic  [NUM_CPU-1:0] own_vec;

    for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
        assign match_vec[g]  = tab_q[g].valid && (tab_q[g].gran == granule);
        assign own_vec[g]    = match_vec[g] && (CPU_W'(g) == cpu);
        assign slot_valid[g] = tab_q[g].valid;
    end

    assign own_hit = |own_vec;

    always_comb begin
        tab_d = tab_q;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (rec_en && (CPU_W'(i) == cpu)) begin
                tab_d[i].valid = 1'b1;
                tab_d[i].gran  = granule;
            end else if (clr_match_en && match_vec[i]) begin
                tab_d[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_q <= '0;
        end else begin
            tab_q <= tab_d;
        end
    end
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
    import excl_mon_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 32,
    parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CPU_W-1:0]  req_cpu,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size,
    input  logic              req_shared,
    input  logic [1:0]        align_cfg,
    output logic              rsp_valid,
    output logic              rsp_status,
    output logic              rsp_wr_en,
    output logic              rsp_align_fault
);
    localparam int GRAN_W = ADDR_W - 2;

    excl_op_e           op;
    logic               is_excl;
    logic               fault;
    logic               do_ldex, do_stex, do_store;
    logic               stex_pass;
    logic               own_hit;
    logic               own_local;
    logic [NUM_CPU-1:0] local_flags;
    logic [NUM_CPU-1:0] glb_valid;
    logic [GRAN_W-1:0]  granule;
    excl_rsp_t          rsp_d, rsp_q;

    assign op      = excl_op_e'(req_op);
    assign is_excl = (op == OP_LDEX) || (op == OP_STEX);
    assign granule = req_addr[ADDR_W-1:2];

    excl_align_chk u_align (
        .is_excl   (is_excl),
        .size_word (req_size),
        .addr_lo   (req_addr[1:0]),
        .align_cfg (align_cfg),
        .fault     (fault)
    );

    always_comb begin
        own_local = 1'b0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (CPU_W'(i) == req_cpu) begin
                own_local = local_flags[i];
            end
        end
        do_ldex   = req_valid && (op == OP_LDEX) && !fault;
        do_stex   = req_valid && (op == OP_STEX) && !fault;
        do_store  = req_valid && (op == OP_STORE);
        stex_pass = do_stex && own_local && (!req_shared || own_hit);
    end

    excl_local_mon #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) u_local (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_en (do_ldex),
        .clr_en (do_stex),
        .cpu    (req_cpu),
        .flags  (local_flags)
    );

    excl_global_mon #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W),
        .GRAN_W  (GRAN_W)
    ) u_global (
        .clk          (clk),
        .rst_n        (rst_n),
        .rec_en       (do_ldex && req_shared),
        .clr_match_en (do_store || (stex_pass && req_shared)),
        .cpu          (req_cpu),
        .granule      (granule),
        .own_hit      (own_hit),
        .slot_valid   (glb_valid)
    );

    always_comb begin
        rsp_d = '0;
        if (req_valid) begin
            rsp_d.valid  = 1'b1;
            rsp_d.fault  = fault;
            rsp_d.wr_en  = stex_pass || do_store;
            rsp_d.status = fault || ((op == OP_STEX) && !stex_pass);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid       = rsp_q.valid;
    assign rsp_status      = rsp_q.status;
    assign rsp_wr_en       = rsp_q.wr_en;
    assign rsp_align_fault = rsp_q.fault;
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [CPU_W-1:0]   req_cpu,
    input logic [1:0]         req_op,
    input logic               rsp_valid,
    input logic               rsp_status,
    input logic               rsp_wr_en,
    input logic               rsp_align_fault,
    input logic [NUM_CPU-1:0] local_flags,
    input logic [NUM_CPU-1:0] glb_valid
);
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && !rsp_wr_en && !rsp_status && !rsp_align_fault);

    a_r2_ldex_arms_local: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 2'd2 |=> rsp_align_fault || local_flags[$past(req_cpu)]);

    a_r3_stex_unarmed_fails: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 2'd3 && !local_flags[req_cpu] |=> rsp_status && !rsp_wr_en);

    a_r6_stex_disarms_local: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 2'd3 |=> rsp_align_fault || !local_flags[$past(req_cpu)]);

    a_r8_store_writes: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 2'd1 |=> rsp_wr_en && !rsp_status && $stable(local_flags));

    a_r9_fault_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_align_fault |-> rsp_status && !rsp_wr_en);

    a_r11_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 2'd0 |=> !rsp_wr_en && !rsp_status
                                         && $stable(local_flags) && $stable(glb_valid));
endmodule

bind excl_monitor excl_monitor_chk #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_cpu         (req_cpu),
    .req_op          (req_op),
    .rsp_valid       (rsp_valid),
    .rsp_status      (rsp_status),
    .rsp_wr_en       (rsp_wr_en),
    .rsp_align_fault (rsp_align_fault),
    .local_flags     (local_flags),
    .glb_valid       (glb_valid)
);

// File: tb/tb_excl_monitor.sv
`timescale 1ns/100ps
module tb_excl_monitor;
    localparam int NCPU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_cpu = '0;
    logic [1:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic        req_size = 1'b0;
    logic        req_shared = 1'b0;
    logic [1:0]  align_cfg = '0;
    logic        rsp_valid, rsp_status, rsp_wr_en, rsp_align_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit mon_en = 0;

    logic [2:0] exp_q[$];
    string      tag_q[$];

    bit          m_local[NCPU];
    bit          m_gv[NCPU];
    logic [29:0] m_ga[NCPU];

    always #2.5 clk = ~clk;

    excl_monitor dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_cpu (req_cpu),
        .req_op (req_op), .req_addr (req_addr), .req_size (req_size),
        .req_shared (req_shared), .align_cfg (align_cfg), .rsp_valid (rsp_valid),
        .rsp_status (rsp_status), .rsp_wr_en (rsp_wr_en), .rsp_align_fault (rsp_align_fault)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Driver: models R2-R11 and pushes {status, wr_en, fault}
    task automatic send(input int cpu, input int op, input logic [31:0] addr,
                        input bit word, input bit shared, input logic [1:0] cfg,
                        input string tag);
        bit flt, pass;
        logic [29:0] gran;
        logic [2:0] e;
        @(negedge clk);
        gran = addr[31:2];
        flt = (op >= 2) && (cfg != 0) && (word ? (addr[1:0] != 0) : addr[0]);
        if (flt) e = 3'b101;
        else begin
            case (op)
                0: e = 3'b000;
                1: begin
                    e = 3'b010;
                    for (int i = 0; i < NCPU; i++) if (m_gv[i] && m_ga[i] == gran) m_gv[i] = 0;
                end
                2: begin
                    e = 3'b000;
                    m_local[cpu] = 1;
                    if (shared) begin m_gv[cpu] = 1; m_ga[cpu] = gran; end
                end
                default: begin
                    pass = m_local[cpu] && (!shared || (m_gv[cpu] && m_ga[cpu] == gran));
                    m_local[cpu] = 0;
                    if (pass && shared)
                        for (int i = 0; i < NCPU; i++) if (m_gv[i] && m_ga[i] == gran) m_gv[i] = 0;
                    e = {!pass, pass, 1'b0};
                end
            endcase
        end
        req_valid = 1; req_cpu = cpu[1:0]; req_op = op[1:0]; req_addr = addr;
        req_size = word; req_shared = shared; align_cfg = cfg;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 0;
    endtask

    // Monitor: pops expected items as responses appear
    always @(negedge clk) begin
        if (mon_en && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R1 unexpected response", {1'b1, rsp_status, rsp_wr_en, rsp_align_fault}, 4'b0000);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {1'b1, rsp_status, rsp_wr_en, rsp_align_fault}, {1'b1, e});
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCPU; i++) begin m_local[i] = 0; m_gv[i] = 0; m_ga[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {rsp_valid, rsp_status, rsp_wr_en, rsp_align_fault}, 4'b0000);
        rst_n = 1;
        mon_en = 1;

        send(0, 3, 32'h100, 1, 0, 0, "R3 stex without reservation");
        send(0, 2, 32'h100, 1, 0, 0, "R2 ldex nonshared");
        send(0, 3, 32'h100, 1, 0, 0, "R5 nonshared stex passes");
        send(0, 3, 32'h100, 1, 0, 0, "R6 repeat stex fails");
        send(1, 2, 32'h200, 1, 1, 0, "R2 ldex shared");
        send(1, 3, 32'h200, 1, 1, 0, "R4 shared stex match passes");
        send(1, 2, 32'h200, 1, 1, 0, "R2 ldex shared again");
        send(1, 3, 32'h204, 1, 1, 0, "R4 shared stex other word fails");
        send(0, 2, 32'h300, 1, 1, 0, "R2 ldex cpu0");
        send(2, 2, 32'h300, 1, 1, 0, "R2 ldex cpu2 same word");
        send(0, 3, 32'h300, 1, 1, 0, "R7 first stex passes");
        send(2, 3, 32'h300, 1, 1, 0, "R7 second stex fails");
        send(3, 2, 32'h400, 1, 1, 0, "R2 ldex cpu3");
        send(1, 1, 32'h402, 0, 0, 0, "R8 halfword store inside word");
        send(3, 3, 32'h400, 1, 1, 0, "R8 stex after store fails");
        send(3, 2, 32'h440, 1, 0, 0, "R2 ldex nonshared cpu3");
        send(2, 1, 32'h440, 1, 0, 0, "R8 store leaves local flag");
        send(3, 3, 32'h440, 1, 0, 0, "R8 local survives store");
        send(0, 2, 32'h501, 0, 0, 2'b01, "R9 halfword fault");
        send(0, 3, 32'h500, 0, 0, 0, "R9 fault armed nothing");
        send(0, 2, 32'h502, 1, 0, 2'b10, "R9 word fault");
        send(0, 2, 32'h501, 0, 0, 2'b00, "R9 no check, no fault");
        send(0, 3, 32'h500, 0, 0, 0, "R9 unchecked ldex armed");
        send(2, 2, 32'h600, 1, 1, 0, "R10 word ldex");
        send(2, 3, 32'h602, 0, 1, 0, "R10 halfword stex passes");
        send(1, 2, 32'h700, 1, 1, 0, "R11 ldex before load");
        send(0, 0, 32'h700, 1, 1, 0, "R11 load quiet");
        send(1, 3, 32'h700, 1, 1, 0, "R11 reservation intact");
        idle();
        idle();
        check("R1 idle cycle", {rsp_valid, rsp_status, rsp_wr_en, rsp_align_fault}, 4'b0000);

        for (int n = 0; n < 400; n++) begin
            int op;
            logic [1:0] cfg;
            op = $urandom % 4;
            cfg = (($urandom % 4) == 0) ? 2'($urandom % 4) : 2'b00;
            send($urandom % NCPU, op, 32'h800 | ($urandom % 16), $urandom % 2, $urandom % 2, cfg,
                 op == 3 ? "R4 random stex" : (op == 2 ? "R2 random ldex" :
                 (op == 1 ? "R8 random store" : "R11 random load")));
        end
        idle();
        idle();
        check("R1 all responses seen", {1'b0, 3'(exp_q.size())}, 4'b0000);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule